// File: doc/BRIEF.md
# Dock Execution Unit

This block executes dock instructions one at a time on behalf of an instruction ring. It holds a single 37-bit data latch. A normal instruction is a set of independent flags: wait for a token, wait for a data item, capture the received word, emit the latch as a data packet, and emit a token. These come with a qualifier that holds back the token until the last pass, and a repeat count that either repeats the instruction in place or hands it back to the ring for requeueing. A literal instruction sign-extends its payload into the latch.

The ring offers an instruction through `insn_valid`/`insn_in`, and the unit accepts it with `insn_take`. Arriving packets come from an input FIFO as a token flag plus a word, under a valid/ready handshake. Outgoing 49-bit packets leave under a valid/ready handshake. When the unit finishes with an instruction, it pulses either `done_retire` or `done_requeue`. On a requeue, `requeue_insn` carries the updated instruction. The parameter `IS_OUTPUT` selects whether the unit serves an output dock or an input dock. On an output dock, emitting data and a token together routes the data along the top 11 bits of the latch. On an input dock, waiting for a token and for data together is an illegal combination.

Top module: `dock_exec`

## Requirements
- R1: After synchronous reset the unit holds an empty latch and is idle: no input ready, no output valid, no completion strobe, no error, and `insn_take` follows `insn_valid`.
- R2: Normal instruction layout: bit 24 = 0, bit 23 wait-token, 22 wait-data, 21 capture, 20 emit-data, 19 emit-token, 18 token-on-last-only, 17 requeue, 16:11 count, 10:0 destination. A packet is bit 48 token flag, 47:37 path, 36:0 word. Emit-data alone sends {0, destination, latch}. Emit-token alone sends {1, destination, zero word}.
- R3: With either wait flag set, each execution consumes exactly one input packet before it emits anything. With neither set, no input is consumed. Input ready and output valid are never high together.
- R4: Capture with wait-data loads the word of an arriving data packet into the latch. An arriving token leaves the latch unchanged. A data packet taken under wait-token alone is acknowledged and its value is dropped.
- R5: On an output dock, emit-data together with an active emit-token sends one data packet whose path is latch bits 36:26.
- R6: With token-on-last-only set, emit-token counts only in the execution whose count is 0.
- R7: After each execution, a count of 0 retires the instruction. Otherwise a non-requeue instruction runs again with the count lowered by one, so a count of n gives n+1 executions. Each instruction ends with exactly one strobe.
- R8: A requeue instruction with a nonzero count executes once, then pulses `done_requeue` with `requeue_insn` equal to the instruction with its count lowered by one (count 63 stays 63).
- R9: Count 63 without requeue is a standing instruction: it repeats without decrementing and never retires.
- R10: Literal layout: bit 24 = 1, bits 23:0 value. The value is sign-extended into the latch, there is no input or output, and the instruction retires.
- R11: Capture without wait-data, token-on-last-only without emit-token, and (on an input dock) both wait flags together raise `err` for one cycle. Such an instruction retires with no input, no output and no latch change.
- R12: A valid output packet stays valid and unchanged until `out_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Ring presents an instruction |
| insn_in | input | 25 | Instruction from the ring |
| insn_take | output | 1 | Instruction accepted this cycle |
| in_valid | input | 1 | Input FIFO has a packet |
| in_tok | input | 1 | Head packet is a token |
| in_word | input | 37 | Head packet word |
| in_ready | output | 1 | Head packet is acknowledged |
| out_valid | output | 1 | Outgoing packet valid |
| out_pkt | output | 49 | Outgoing packet {token, path, word} |
| out_ready | input | 1 | Fabric accepts the packet |
| done_retire | output | 1 | Instruction discarded |
| done_requeue | output | 1 | Instruction to be written back to the ring |
| requeue_insn | output | 25 | Instruction with updated count for requeue |
| err | output | 1 | Illegal flag combination seen |

## Verification
The bench targets the cases where a count boundary meets a flag. One case is the token that is held back until count zero: a design that tests the count after decrementing emits one pass early or never. Another is the output-dock send along a path taken from the latch: a design that takes the low latch bits or the destination field routes to the wrong place. Other targets are a token arriving under capture, where a design that captures anyway destroys the latch, and requeue at the standing count, where decrementing turns a standing instruction into a finite one. Illegal combinations are sent with a packet waiting in the FIFO, so a design that acknowledges it or emits is caught.

// File: rtl/dock_exec_pkg.sv
package dock_exec_pkg;

    localparam int WORD_W = 37;
    localparam int PATH_W = 11;
    localparam int CNT_W  = 6;
    localparam int NFLAG  = 7;
    localparam int BODY_W = NFLAG + CNT_W + PATH_W;
    localparam int INSN_W = BODY_W + 1;
    localparam int PKT_W  = 1 + PATH_W + WORD_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic               wait_tok;
        logic               wait_dat;
        logic               capture;
        logic               emit_dat;
        logic               emit_tok;
        logic               tok_last;
        logic               requeue;
        logic [CNT_W-1:0]   count;
        logic [PATH_W-1:0]  dest;
    } normal_t;

    typedef struct packed {
        logic               tok;
        logic [PATH_W-1:0]  path;
        logic [WORD_W-1:0]  word;
    } pkt_t;

    typedef enum logic [1:0] {ST_IDLE, ST_IN, ST_OUT} st_t;
    typedef enum logic [1:0] {DISP_RETIRE, DISP_REPEAT, DISP_REQUEUE} disp_t;

    function automatic logic [WORD_W-1:0] sext_lit(input logic [BODY_W-1:0] v);
        return {{(WORD_W-BODY_W){v[BODY_W-1]}}, v};
    endfunction

endpackage

// File: rtl/dock_exec_decode.sv
module dock_exec_decode
    import dock_exec_pkg::*;
#(
    parameter bit IS_OUTPUT = 1'b1
) (
    input  logic [INSN_W-1:0] insn,
    output logic              is_lit,
    output normal_t           fld,
    output logic [WORD_W-1:0] lit_word,
    output logic              reserved,
    output logic              need_in,
    output logic              emit_d,
    output logic              emit_t
);
    logic both_wait_bad;

    assign is_lit   = insn[INSN_W-1];
    assign fld      = normal_t'(insn[BODY_W-1:0]);
    assign lit_word = sext_lit(insn[BODY_W-1:0]);

    generate
        if (IS_OUTPUT) begin : g_outdock
            assign both_wait_bad = 1'b0;
        end else begin : g_indock
            assign both_wait_bad = fld.wait_tok & fld.wait_dat;
        end
    endgenerate

    assign reserved = both_wait_bad
                    | (~fld.wait_dat & fld.capture)
                    | (~fld.emit_tok & fld.tok_last);
    assign need_in  = fld.wait_tok | fld.wait_dat;
    assign emit_d   = fld.emit_dat;
    assign emit_t   = fld.emit_tok & (~fld.tok_last | (fld.count == '0));
endmodule

// File: rtl/dock_exec_count.sv
module dock_exec_count
    import dock_exec_pkg::*;
(
    input  logic [CNT_W-1:0] count,
    input  logic             requeue,
    output logic [CNT_W-1:0] cnt_next,
    output disp_t            disp
);
    always_comb begin
        cnt_next = (count == CNT_MAX) ? count : count - 1'b1;
        if (count == '0)
            disp = DISP_RETIRE;
        else if (requeue)
            disp = DISP_REQUEUE;
        else
            disp = DISP_REPEAT;
    end
endmodule

// File: rtl/dock_exec_pkt.sv
module dock_exec_pkt
    import dock_exec_pkg::*;
#(
    parameter bit IS_OUTPUT = 1'b1
) (
    input  logic [WORD_W-1:0] latch,
    input  logic [PATH_W-1:0] dest,
    input  logic              emit_d,
    input  logic              emit_t,
    output logic [PKT_W-1:0]  pkt
);
    logic [PATH_W-1:0] data_path;
    pkt_t              p;

    generate
        if (IS_OUTPUT) begin : g_self_route
            assign data_path = emit_t ? latch[WORD_W-1 -: PATH_W] : dest;
        end else begin : g_fixed_route
            assign data_path = dest;
        end
    endgenerate

    always_comb begin
        if (emit_d) begin
            p.tok  = 1'b0;
            p.path = data_path;
            p.word = latch;
        end else begin
            p.tok  = 1'b1;
            p.path = dest;
            p.word = '0;
        end
    end

    assign pkt = p;
endmodule

// File: rtl/dock_exec.sv
module dock_exec
    import dock_exec_pkg::*;
#(
    parameter bit IS_OUTPUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn_in,
    output logic              insn_take,
    input  logic              in_valid,
    input  logic              in_tok,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic              out_valid,
    output logic [PKT_W-1:0]  out_pkt,
    input  logic              out_ready,
    output logic              done_retire,
    output logic              done_requeue,
    output logic [INSN_W-1:0] requeue_insn,
    output logic              err
);
    st_t               st;
    logic [INSN_W-1:0] cur;
    logic [WORD_W-1:0] latch;

    logic              is_lit, reserved, need_in, emit_d, emit_t;
    normal_t           fld, nxt;
    logic [WORD_W-1:0] lit_word;
    logic [CNT_W-1:0]  cnt_next;
    disp_t             disp;
    logic              finish, force_ret, go_out;

    dock_exec_decode #(.IS_OUTPUT(IS_OUTPUT)) u_dec (
        .insn(cur), .is_lit(is_lit), .fld(fld), .lit_word(lit_word),
        .reserved(reserved), .need_in(need_in), .emit_d(emit_d), .emit_t(emit_t)
    );

    dock_exec_count u_cnt (
        .count(fld.count), .requeue(fld.requeue), .cnt_next(cnt_next), .disp(disp)
    );

    dock_exec_pkt #(.IS_OUTPUT(IS_OUTPUT)) u_pkt (
        .latch(latch), .dest(fld.dest), .emit_d(emit_d), .emit_t(emit_t), .pkt(out_pkt)
    );

    always_comb begin
        nxt       = fld;
        nxt.count = cnt_next;
    end
    assign requeue_insn = {1'b0, nxt};

    always_comb begin
        insn_take = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        finish    = 1'b0;
        force_ret = 1'b0;
        err       = 1'b0;
        go_out    = 1'b0;
        unique case (st)
            ST_IDLE: insn_take = insn_valid;
            ST_IN: begin
                if (is_lit) begin
                    finish    = 1'b1;
                    force_ret = 1'b1;
                end else if (reserved) begin
                    finish    = 1'b1;
                    force_ret = 1'b1;
                    err       = 1'b1;
                end else if (need_in) begin
                    in_ready = 1'b1;
                    go_out   = in_valid;
                end else begin
                    go_out = 1'b1;
                end
            end
            ST_OUT: begin
                out_valid = emit_d | emit_t;
                finish    = ~(emit_d | emit_t) | out_ready;
            end
            default: ;
        endcase
        done_retire  = finish & (force_ret | (disp == DISP_RETIRE));
        done_requeue = finish & ~force_ret & (disp == DISP_REQUEUE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cur   <= '0;
            latch <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (insn_valid) begin
                        cur <= insn_in;
                        st  <= ST_IN;
                    end
                end
                ST_IN: begin
                    if (is_lit) begin
                        latch <= lit_word;
                        st    <= ST_IDLE;
                    end else if (reserved) begin
                        st <= ST_IDLE;
                    end else if (go_out) begin
                        if (in_ready && fld.wait_dat && fld.capture && !in_tok)
                            latch <= in_word;
                        st <= ST_OUT;
                    end
                end
                ST_OUT: begin
                    if (finish) begin
                        if (disp == DISP_REPEAT) begin
                            cur <= requeue_insn;
                            st  <= ST_IN;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dock_exec_chk.sv
module dock_exec_chk
    import dock_exec_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PKT_W-1:0] out_pkt,
    input logic             done_retire,
    input logic             done_requeue,
    input logic             err
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && !in_ready && !done_retire && !done_requeue && !err));

    assert_in_out_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        !(done_retire && done_requeue));

    assert_err_retires_R11: assert property (@(posedge clk) disable iff (rst)
        err |-> (done_retire && !out_valid && !in_ready));

    assert_hold_out_R12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pkt)));
endmodule

bind dock_exec dock_exec_chk u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_pkt(out_pkt), .done_retire(done_retire),
    .done_requeue(done_requeue), .err(err)
);

// File: tb/dock_exec_test.sv
module dock_exec_test;
    import dock_exec_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              insn_valid;
    logic [INSN_W-1:0] insn_in;
    logic              insn_take;
    logic              in_valid;
    logic              in_tok;
    logic [WORD_W-1:0] in_word;
    logic              in_ready;
    logic              out_valid;
    logic [PKT_W-1:0]  out_pkt;
    logic              out_ready;
    logic              done_retire;
    logic              done_requeue;
    logic [INSN_W-1:0] requeue_insn;
    logic              err;

    always #5 clk = ~clk;

    dock_exec #(.IS_OUTPUT(1'b1)) uut (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_in(insn_in),
        .insn_take(insn_take), .in_valid(in_valid), .in_tok(in_tok),
        .in_word(in_word), .in_ready(in_ready), .out_valid(out_valid),
        .out_pkt(out_pkt), .out_ready(out_ready), .done_retire(done_retire),
        .done_requeue(done_requeue), .requeue_insn(requeue_insn), .err(err)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [WORD_W:0]   inq[$];
    logic [WORD_W:0]   mstim[$];
    logic [PKT_W-1:0]  obs_q[$];
    logic [PKT_W-1:0]  exp_q[$];
    logic [WORD_W-1:0] mlatch;
    int                exp_kind;
    logic [INSN_W-1:0] exp_rq;
    bit                exp_err;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements): actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    function automatic logic [INSN_W-1:0] nrm(bit wt, bit wd, bit dc, bit dout, bit to,
            bit ig, bit rq, logic [CNT_W-1:0] c, logic [PATH_W-1:0] d);
        return {1'b0, wt, wd, dc, dout, to, ig, rq, c, d};
    endfunction

    function automatic logic [INSN_W-1:0] lit(logic [BODY_W-1:0] v);
        return {1'b1, v};
    endfunction

    function automatic logic [WORD_W-1:0] lit_ext(logic [BODY_W-1:0] v);
        logic [WORD_W-1:0] w;
        w = {{(WORD_W-BODY_W){1'b0}}, v};
        if (v[BODY_W-1]) w = w | ({WORD_W{1'b1}} << BODY_W);
        return w;
    endfunction

    task automatic stim(input bit tok, input logic [WORD_W-1:0] w);
        inq.push_back({tok, w});
        mstim.push_back({tok, w});
    endtask

    task automatic do_reset();
        rst = 1'b1; insn_valid = 1'b0; insn_in = '0; in_valid = 1'b0;
        in_tok = 1'b0; in_word = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mlatch = '0;
    endtask

    task automatic model(input logic [INSN_W-1:0] ins, input int lim);
        normal_t           f, g;
        logic [CNT_W-1:0]  c, nc;
        logic [WORD_W:0]   p;
        logic [PATH_W-1:0] pth;
        bit                ed, et;
        int                ex;
        exp_kind = 0; exp_err = 1'b0; exp_q.delete();
        f = normal_t'(ins[BODY_W-1:0]);
        if (ins[INSN_W-1]) begin
            mlatch = lit_ext(ins[BODY_W-1:0]); exp_kind = 1; return;
        end
        if ((!f.wait_dat && f.capture) || (!f.emit_tok && f.tok_last)) begin
            exp_err = 1'b1; exp_kind = 1; return;
        end
        c = f.count; ex = 0;
        forever begin
            if (f.wait_tok || f.wait_dat) begin
                p = mstim.pop_front();
                if (f.wait_dat && f.capture && !p[WORD_W]) mlatch = p[WORD_W-1:0];
            end
            ed = f.emit_dat;
            et = f.emit_tok && (!f.tok_last || c == 0);
            if (ed) begin
                pth = et ? mlatch[WORD_W-1:WORD_W-PATH_W] : f.dest;
                exp_q.push_back({1'b0, pth, mlatch});
            end else if (et) begin
                exp_q.push_back({1'b1, f.dest, {WORD_W{1'b0}}});
            end
            ex++;
            if (c == 0) begin exp_kind = 1; return; end
            nc = (c == CNT_MAX) ? c : c - 1'b1;
            if (f.requeue) begin
                g = f; g.count = nc; exp_rq = {1'b0, g}; exp_kind = 2; return;
            end
            c = nc;
            if (lim > 0 && ex >= lim) return;
        end
    endtask

    task automatic run(input logic [INSN_W-1:0] ins, input int lim, output int kind,
                       output logic [INSN_W-1:0] rq, output bit saw_err);
        bit taken = 0;
        kind = 0; rq = '0; saw_err = 0;
        @(negedge clk);
        for (int cyc = 0; cyc < 600; cyc++) begin
            insn_valid = !taken;
            insn_in    = ins;
            in_valid   = (inq.size() > 0) && ($urandom % 4 != 0);
            {in_tok, in_word} = (inq.size() > 0) ? inq[0] : '0;
            out_ready  = ($urandom % 3 != 0);
            #1;
            if (insn_take) taken = 1;
            if (in_valid && in_ready) void'(inq.pop_front());
            if (out_valid && out_ready) obs_q.push_back(out_pkt);
            if (err) saw_err = 1;
            if (done_retire) kind = 1;
            if (done_requeue) begin kind = 2; rq = requeue_insn; end
            @(negedge clk);
            if (kind != 0) break;
            if (lim > 0 && obs_q.size() >= lim) break;
        end
        insn_valid = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    endtask

    task automatic go(input logic [INSN_W-1:0] ins, input int lim, input string req);
        int                kind;
        logic [INSN_W-1:0] rq;
        bit                e;
        model(ins, lim);
        run(ins, lim, kind, rq, e);
        chk(obs_q.size() == exp_q.size(), req, "packet count", obs_q.size(), exp_q.size());
        foreach (exp_q[i])
            if (i < obs_q.size())
                chk(obs_q[i] == exp_q[i], req, "packet", 64'(obs_q[i]), 64'(exp_q[i]));
        chk(kind == exp_kind, req, "completion kind", kind, exp_kind);
        if (exp_kind == 2) chk(rq == exp_rq, req, "requeue instruction", 64'(rq), 64'(exp_rq));
        chk(e == exp_err, req, "err", e, exp_err);
        chk(inq.size() == mstim.size(), req, "inputs left", inq.size(), mstim.size());
        obs_q.delete(); exp_q.delete(); inq.delete(); mstim.delete();
    endtask

    initial begin
        logic [INSN_W-1:0] show;
        logic [WORD_W-1:0] w;
        rst = 1'b1;
        do_reset();
        show = nrm(0, 0, 0, 1, 0, 0, 0, 6'd0, 11'h005);

        // R1: reset state
        @(negedge clk);
        insn_valid = 1'b1; insn_in = show; #1;
        chk(!out_valid && !in_ready && !done_retire && !done_requeue && !err, "R1",
            "idle outputs", {out_valid, in_ready, done_retire, done_requeue, err}, 0);
        chk(insn_take == 1'b1, "R1", "take follows valid", insn_take, 1);
        insn_valid = 1'b0;
        go(show, 0, "R1 R2 empty latch");

        // R10: literals, observed through an emit-data instruction (R2)
        go(lit(24'h012345), 0, "R10 positive literal");
        go(show, 0, "R10 R2 read back");
        go(lit(24'h800123), 0, "R10 negative literal");
        go(show, 0, "R10 R2 read back sign");

        // R4: capture of data, token leaves latch alone
        stim(0, 37'h0_1234_5678);
        go(nrm(0, 1, 1, 0, 0, 0, 0, 6'd0, 11'h000), 0, "R4 capture data");
        go(show, 0, "R4 read back");
        stim(1, 37'h1F_FFFF_FFFF);
        go(nrm(0, 1, 1, 0, 0, 0, 0, 6'd0, 11'h000), 0, "R4 token not captured");
        go(show, 0, "R4 read back after token");
        stim(0, 37'h0_0BAD_BEEF);
        go(nrm(1, 0, 0, 0, 1, 0, 0, 6'd0, 11'h3C1), 0, "R4 R3 data under wait-token");
        go(show, 0, "R4 value dropped");

        // R3: no wait flag leaves the FIFO untouched
        stim(0, 37'h0_0000_0077);
        go(nrm(0, 0, 0, 0, 1, 0, 0, 6'd0, 11'h011), 0, "R3 no input consumed");

        // R5: self-routed send on the output dock
        w = {11'h5A3, 26'h123_4567};
        stim(0, w);
        go(nrm(0, 1, 1, 0, 0, 0, 0, 6'd0, 11'h000), 0, "R5 load");
        go(nrm(0, 0, 0, 1, 1, 0, 0, 6'd0, 11'h002), 0, "R5 path from latch");

        // R6: token held until count zero
        go(nrm(0, 0, 0, 0, 1, 1, 0, 6'd3, 11'h044), 0, "R6 token on last");
        go(nrm(0, 0, 0, 1, 1, 1, 0, 6'd2, 11'h045), 0, "R6 R5 late self-route");

        // R7: repeat count with waits
        for (int i = 0; i < 4; i++) stim(i % 2, 37'(i * 13 + 1));
        go(nrm(1, 0, 0, 0, 1, 0, 0, 6'd3, 11'h123), 0, "R7 R3 repeat four times");

        // R8: requeue
        stim(0, 37'h0_0000_ABCD);
        go(nrm(0, 1, 1, 1, 0, 0, 1, 6'd5, 11'h00F), 0, "R8 requeue decrement");
        go(nrm(0, 0, 0, 0, 1, 0, 1, CNT_MAX, 11'h0F0), 0, "R8 requeue standing");
        go(nrm(0, 0, 0, 1, 0, 0, 1, 6'd0, 11'h0F1), 0, "R8 R7 requeue at zero retires");

        // R11: illegal combinations
        stim(0, 37'h0_0000_1111);
        go(nrm(0, 0, 1, 1, 0, 0, 0, 6'd0, 11'h001), 0, "R11 capture without wait");
        stim(0, 37'h0_0000_2222);
        go(nrm(1, 1, 1, 1, 0, 1, 0, 6'd0, 11'h001), 0, "R11 last-only without token");
        go(show, 0, "R11 latch unchanged");

        // R9: standing instruction, stopped by reset
        go(nrm(0, 0, 0, 0, 1, 0, 0, CNT_MAX, 11'h222), 5, "R9 standing repeat");
        do_reset();

        // R12 R7: random legal instructions under back-pressure
        for (int t = 0; t < 60; t++) begin
            bit wt, wd, dc, dout, to, ig, rq;
            logic [CNT_W-1:0] c;
            int nex;
            wt = $urandom % 2; wd = $urandom % 2; dc = wd ? $urandom % 2 : 0;
            dout = $urandom % 2; to = $urandom % 2; ig = to ? $urandom % 2 : 0;
            rq = $urandom % 2; c = CNT_W'($urandom % 4);
            nex = (rq && c != 0) ? 1 : int'(c) + 1;
            if (wt || wd)
                for (int k = 0; k < nex; k++)
                    stim($urandom % 2, {5'($urandom), 32'($urandom)});
            go(nrm(wt, wd, dc, dout, to, ig, rq, c, 11'($urandom)), 0, "R12 R7 random");
            if (t % 7 == 0) go(show, 0, "R12 R4 random read back");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        process::self().srandom(32'd20240611);
    end
endmodule